// File: doc/BRIEF.md
# Host and Microsequencer Command/Status Handshake Register

This block is the single control and status word shared by a host bus and an embedded microsequencer inside an arithmetic accelerator. It holds three things. The first is a sequencer hold bit that keeps the sequencer in reset. The second is a status byte that only the sequencer can write. The third is a command byte with split ownership: the host may only raise bits and the sequencer may only lower them. This lets either side post or acknowledge work without a read-modify-write race.

The lowest status bit is active low. Its complement drives the sequencer interrupt and is also merged into the run indication the host polls, so a sequencer that signals "busy" keeps the host waiting even when the arithmetic core is idle. A host write to the accelerator's function word that sets run with a nonzero operation code posts command bit 0 on its own.

The hold bit also steers the host's memory window. While the sequencer is held, only program memory is reachable. Once it is released, only data memory is reachable. A blocked access reads as zero and its write is discarded.

Top module: `seq_handshake_csr`

## Requirements
- R1: After reset the register reads with the hold bit (bit DW-1) equal to the RST_HOLD parameter (default 1), the status byte (bits [15:8]) equal to 0x01, the command byte (bits [7:0]) equal to 0x00, and all other bits zero; `seq_rst` mirrors the hold bit.
- R2: A host register write loads bit DW-1 into the hold bit one cycle later, but only when `run_vis` is 0 in the write cycle; with `run_vis` at 1 the hold bit keeps its value.
- R3: The status byte changes only on a sequencer write, which loads `s_wdata[15:8]`; host writes to bits [15:8] have no effect.
- R4: `seq_irq` equals the inverse of status bit 0 (register bit 8), and `run_vis` equals `core_run` OR `seq_irq`.
- R5: A host register write with data bit i (i in 0..7) at 1 sets command bit i; a host data bit at 0 leaves command bit i unchanged.
- R6: A sequencer write with `s_wdata[i]` at 0 clears command bit i; a 1 leaves it unchanged, so the sequencer can never set a command bit.
- R7: When a host set and a sequencer clear hit the same command bit in one cycle, the bit ends up set.
- R8: A function write (`h_fn_we`) with `h_fn_run` at 1 and a nonzero `h_fn_op` sets command bit 0; with `h_fn_op` equal to 0 or `h_fn_run` at 0 it does not.
- R9: With the hold bit at 1, host accesses with `h_mem_sel`=0 reach program memory and those with `h_mem_sel`=1 are blocked; with the hold bit at 0 the roles swap.
- R10: A blocked read returns zero on `h_mem_rdata` and raises no read strobe; a blocked write raises no write strobe, so the memory keeps its previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_csr_we | input | 1 | Host write strobe for the handshake register |
| h_csr_wdata | input | DW | Host write data |
| h_csr_rdata | output | DW | Current register value as seen by the host |
| h_fn_we | input | 1 | Host write strobe for the accelerator function word |
| h_fn_run | input | 1 | Run bit of that function write |
| h_fn_op | input | OP_W | Sequencer operation code of that function write |
| core_run | input | 1 | Busy flag of the arithmetic core |
| run_vis | output | 1 | Run indication seen by the host |
| seq_irq | output | 1 | Sequencer interrupt |
| seq_rst | output | 1 | Hold-in-reset to the sequencer |
| s_we | input | 1 | Sequencer write strobe |
| s_wdata | input | STAT_W+CMD_W | Sequencer data: status in the upper byte, clear mask in the lower |
| s_cmd | output | CMD_W | Command byte as seen by the sequencer |
| h_mem_sel | input | 1 | Host memory target: 0 program, 1 data |
| h_mem_rd | input | 1 | Host memory read request |
| h_mem_wr | input | 1 | Host memory write request |
| h_mem_addr | input | MEM_AW | Host memory word address |
| h_mem_wdata | input | DW | Host memory write data |
| h_mem_rdata | output | DW | Host memory read data, zero when blocked |
| prog_re | output | 1 | Program memory read strobe |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | MEM_AW | Program memory address |
| prog_wdata | output | DW | Program memory write data |
| prog_rdata | input | DW | Program memory read data |
| data_re | output | 1 | Data memory read strobe |
| data_we | output | 1 | Data memory write strobe |
| data_addr | output | MEM_AW | Data memory address |
| data_wdata | output | DW | Data memory write data |
| data_rdata | input | DW | Data memory read data |

## Verification
Several rules are checked on every cycle. The hold bit stays fixed while run is visible. The status byte holds between sequencer writes. The interrupt and run merge follow status bit 0. Host-set bits are present one cycle later, and the sequencer never raises a command bit. No memory strobe fires on the side the hold bit closes. Other behaviour can only be shown through the bench's scenarios, because it needs a memory that outlives the access. A write dropped while the sequencer is held must be absent after release. Blocked reads return zero instead of memory content. Host-versus-sequencer collisions on one bit, and run starts with zero and nonzero operation codes, are set up on purpose and compared against a bench model.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
   // host memory window target
   typedef enum logic {
      SEL_PROG = 1'b0,
      SEL_DATA = 1'b1
   } mem_sel_e;

   // number of gated memory regions
   localparam int unsigned NUM_REGIONS = 2;
endpackage

// File: rtl/hsc_cmd_byte.sv
module hsc_cmd_byte #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_we,
   input  logic [W-1:0] host_wdata,
   input  logic         auto_set,
   input  logic         seq_we,
   input  logic [W-1:0] seq_wdata,
   output logic [W-1:0] cmd
);
   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_auto
         assign set_v[i] = (host_we & host_wdata[i]) | auto_set;
      end else begin : g_plain
         assign set_v[i] = host_we & host_wdata[i];
      end
      assign clr_v[i] = seq_we & ~seq_wdata[i];

      // host set has priority over sequencer clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cmd[i] <= 1'b0;
         else if (set_v[i]) cmd[i] <= 1'b1;
         else if (clr_v[i]) cmd[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/hsc_ctrl_stat.sv
module hsc_ctrl_stat #(
   parameter int unsigned        STAT_W   = 8,
   parameter logic [STAT_W-1:0]  STAT_RST = 'h01,
   parameter bit                 RST_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_hold,
   input  logic              lock,
   input  logic              seq_we,
   input  logic [STAT_W-1:0] seq_stat,
   output logic              hold,
   output logic [STAT_W-1:0] stat
);
   // hold bit: only changed by the host while nothing is running
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                hold <= RST_HOLD;
      else if (host_we && !lock) hold <= host_hold;
   end

   // status byte: sequencer-owned
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stat <= STAT_RST;
      else if (seq_we) stat <= seq_stat;
   end
endmodule

// File: rtl/hsc_mem_gate.sv
module hsc_mem_gate #(
   parameter int unsigned AW          = 10,
   parameter int unsigned DW          = 32,
   parameter bit          OPEN_IN_RST = 1'b1
) (
   input  logic          hold,
   input  logic          req_rd,
   input  logic          req_wr,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_re,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic [DW-1:0] rdata
);
   logic open_w;

   if (OPEN_IN_RST) begin : g_open_held
      assign open_w = hold;
   end else begin : g_open_run
      assign open_w = ~hold;
   end

   always_comb begin
      mem_re    = req_rd & open_w;
      mem_we    = req_wr & open_w;
      mem_addr  = open_w ? addr  : '0;
      mem_wdata = open_w ? wdata : '0;
      rdata     = mem_re ? mem_rdata : '0;
   end
endmodule

// File: rtl/seq_handshake_csr.sv
module seq_handshake_csr #(
   parameter int unsigned       DW       = 32,
   parameter int unsigned       CMD_W    = 8,
   parameter int unsigned       STAT_W   = 8,
   parameter logic [STAT_W-1:0] STAT_RST = 'h01,
   parameter int unsigned       OP_W     = 3,
   parameter int unsigned       MEM_AW   = 10,
   parameter bit                RST_HOLD = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    h_csr_we,
   input  logic [DW-1:0]           h_csr_wdata,
   output logic [DW-1:0]           h_csr_rdata,
   input  logic                    h_fn_we,
   input  logic                    h_fn_run,
   input  logic [OP_W-1:0]         h_fn_op,
   input  logic                    core_run,
   output logic                    run_vis,
   output logic                    seq_irq,
   output logic                    seq_rst,
   input  logic                    s_we,
   input  logic [STAT_W+CMD_W-1:0] s_wdata,
   output logic [CMD_W-1:0]        s_cmd,
   input  logic                    h_mem_sel,
   input  logic                    h_mem_rd,
   input  logic                    h_mem_wr,
   input  logic [MEM_AW-1:0]       h_mem_addr,
   input  logic [DW-1:0]           h_mem_wdata,
   output logic [DW-1:0]           h_mem_rdata,
   output logic                    prog_re,
   output logic                    prog_we,
   output logic [MEM_AW-1:0]       prog_addr,
   output logic [DW-1:0]           prog_wdata,
   input  logic [DW-1:0]           prog_rdata,
   output logic                    data_re,
   output logic                    data_we,
   output logic [MEM_AW-1:0]       data_addr,
   output logic [DW-1:0]           data_wdata,
   input  logic [DW-1:0]           data_rdata
);
   import hsc_pkg::*;

   localparam int unsigned STAT_LSB = CMD_W;
   localparam int unsigned USED_LO  = CMD_W + STAT_W;
   localparam int unsigned HOLD_BIT = DW - 1;

   // elaboration-time parameter checks
   if (USED_LO >= DW) begin : g_bad_width
      $error("status and command fields do not fit below the hold bit");
   end
   if (CMD_W < 1 || STAT_W < 1 || OP_W < 1) begin : g_bad_field
      $error("field widths must be at least one bit");
   end
   if (MEM_AW < 1 || MEM_AW > 30) begin : g_bad_aw
      $error("memory address width out of range");
   end

   logic              hold_q;
   logic [STAT_W-1:0] stat_q;
   logic [CMD_W-1:0]  cmd_q;
   logic              auto_start;
   logic              irq_w;
   logic              run_w;

   assign auto_start = h_fn_we & h_fn_run & (|h_fn_op);
   assign irq_w      = ~stat_q[0];
   assign run_w      = core_run | irq_w;

   hsc_ctrl_stat #(
      .STAT_W   (STAT_W),
      .STAT_RST (STAT_RST),
      .RST_HOLD (RST_HOLD)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .host_we   (h_csr_we),
      .host_hold (h_csr_wdata[HOLD_BIT]),
      .lock      (run_w),
      .seq_we    (s_we),
      .seq_stat  (s_wdata[STAT_LSB +: STAT_W]),
      .hold      (hold_q),
      .stat      (stat_q)
   );

   hsc_cmd_byte #(
      .W (CMD_W)
   ) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (h_csr_we),
      .host_wdata (h_csr_wdata[CMD_W-1:0]),
      .auto_set   (auto_start),
      .seq_we     (s_we),
      .seq_wdata  (s_wdata[CMD_W-1:0]),
      .cmd        (cmd_q)
   );

   // bits of the host word with no writable meaning
   logic unused_wbits;
   assign unused_wbits = ^{h_csr_wdata[HOLD_BIT-1:USED_LO], h_csr_wdata[STAT_LSB +: STAT_W]};

   always_comb begin
      h_csr_rdata                      = '0;
      h_csr_rdata[HOLD_BIT]            = hold_q;
      h_csr_rdata[STAT_LSB +: STAT_W]  = stat_q;
      h_csr_rdata[CMD_W-1:0]           = cmd_q;
   end

   assign run_vis = run_w;
   assign seq_irq = irq_w;
   assign seq_rst = hold_q;
   assign s_cmd   = cmd_q;

   // memory window gating: region 0 open while held, region 1 open while released
   logic [NUM_REGIONS-1:0]             g_re;
   logic [NUM_REGIONS-1:0]             g_we;
   logic [NUM_REGIONS-1:0][MEM_AW-1:0] g_addr;
   logic [NUM_REGIONS-1:0][DW-1:0]     g_wdata;
   logic [NUM_REGIONS-1:0][DW-1:0]     g_mrd;
   logic [NUM_REGIONS-1:0][DW-1:0]     g_rd;

   assign g_mrd[0] = prog_rdata;
   assign g_mrd[1] = data_rdata;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
      logic sel_w;
      assign sel_w = (g == 0) ? (h_mem_sel == SEL_PROG) : (h_mem_sel == SEL_DATA);

      hsc_mem_gate #(
         .AW          (MEM_AW),
         .DW          (DW),
         .OPEN_IN_RST (g == 0)
      ) u_gate (
         .hold      (hold_q),
         .req_rd    (h_mem_rd & sel_w),
         .req_wr    (h_mem_wr & sel_w),
         .addr      (h_mem_addr),
         .wdata     (h_mem_wdata),
         .mem_rdata (g_mrd[g]),
         .mem_re    (g_re[g]),
         .mem_we    (g_we[g]),
         .mem_addr  (g_addr[g]),
         .mem_wdata (g_wdata[g]),
         .rdata     (g_rd[g])
      );
   end

   assign prog_re     = g_re[0];
   assign prog_we     = g_we[0];
   assign prog_addr   = g_addr[0];
   assign prog_wdata  = g_wdata[0];
   assign data_re     = g_re[1];
   assign data_we     = g_we[1];
   assign data_addr   = g_addr[1];
   assign data_wdata  = g_wdata[1];
   assign h_mem_rdata = g_rd[0] | g_rd[1];
endmodule

// File: rtl/hsc_checker.sv
module hsc_checker #(
   parameter int unsigned DW     = 32,
   parameter int unsigned CMD_W  = 8,
   parameter int unsigned STAT_W = 8,
   parameter int unsigned OP_W   = 3
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    h_csr_we,
   input logic [DW-1:0]           h_csr_wdata,
   input logic [DW-1:0]           h_csr_rdata,
   input logic                    h_fn_we,
   input logic                    h_fn_run,
   input logic [OP_W-1:0]         h_fn_op,
   input logic                    core_run,
   input logic                    run_vis,
   input logic                    seq_irq,
   input logic                    seq_rst,
   input logic                    s_we,
   input logic [STAT_W+CMD_W-1:0] s_wdata,
   input logic                    prog_re,
   input logic                    prog_we,
   input logic                    data_re,
   input logic                    data_we
);
   logic start_c;
   assign start_c = h_fn_we & h_fn_run & (|h_fn_op);

   // R2: hold bit frozen while run is visible
   p_hold_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
      run_vis |=> $stable(seq_rst));

   // R2: unlocked host write loads the hold bit
   p_hold_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_csr_we && !run_vis) |=> (seq_rst == $past(h_csr_wdata[DW-1])));

   // R3: status only moves on a sequencer write
   p_stat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !s_we |=> $stable(h_csr_rdata[CMD_W +: STAT_W]));

   // R4: interrupt follows inverted status bit 0
   p_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      seq_irq == !h_csr_rdata[CMD_W]);

   // R4: run merge
   p_run_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      run_vis == (core_run || !h_csr_rdata[CMD_W]));

   // R5, R7: host-set bits are present next cycle regardless of sequencer
   p_host_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      h_csr_we |=> ((h_csr_rdata[CMD_W-1:0] & $past(h_csr_wdata[CMD_W-1:0]))
                    == $past(h_csr_wdata[CMD_W-1:0])));

   // R6: without host set the command byte never gains a bit
   p_no_seq_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!h_csr_we && !start_c) |=>
         ((h_csr_rdata[CMD_W-1:0] & ~$past(h_csr_rdata[CMD_W-1:0])) == '0));

   // R6: sequencer zeros clear
   p_seq_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_we && !h_csr_we && !start_c) |=>
         ((h_csr_rdata[CMD_W-1:0] & ~$past(s_wdata[CMD_W-1:0])) == '0));

   // R8: run with operation posts command bit 0
   p_auto_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> h_csr_rdata[0]);

   // R9: program strobes only while held
   p_prog_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_re || prog_we) |-> seq_rst);

   // R9: data strobes only while released
   p_data_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_re || data_we) |-> !seq_rst);
endmodule

bind seq_handshake_csr hsc_checker #(
   .DW     (DW),
   .CMD_W  (CMD_W),
   .STAT_W (STAT_W),
   .OP_W   (OP_W)
) u_hsc_checker (.*);

// File: tb/seq_handshake_csr_bench.sv
`timescale 1ns/1ps
module seq_handshake_csr_bench;
   localparam int DW = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          h_csr_we = 0;
   logic [31:0]   h_csr_wdata = '0;
   logic [31:0]   h_csr_rdata;
   logic          h_fn_we = 0, h_fn_run = 0;
   logic [2:0]    h_fn_op = '0;
   logic          core_run = 0;
   logic          run_vis, seq_irq, seq_rst;
   logic          s_we = 0;
   logic [15:0]   s_wdata = '0;
   logic [7:0]    s_cmd;
   logic          h_mem_sel = 0, h_mem_rd = 0, h_mem_wr = 0;
   logic [AW-1:0] h_mem_addr = '0;
   logic [31:0]   h_mem_wdata = '0, h_mem_rdata;
   logic          prog_re, prog_we, data_re, data_we;
   logic [AW-1:0] prog_addr, data_addr;
   logic [31:0]   prog_wdata, data_wdata, prog_rdata, data_rdata;

   logic [31:0] prog_mem [16];
   logic [31:0] data_mem [16];

   int checks = 0;
   int errors = 0;

   // expected state
   logic       e_hold;
   logic [7:0] e_stat;
   logic [7:0] e_cmd;

   always #2.5 clk = ~clk;

   seq_handshake_csr #(.MEM_AW(AW)) u_seq_handshake_csr (.*);

   initial for (int i = 0; i < 16; i++) begin
      prog_mem[i] = 32'hA000_0000 + i;
      data_mem[i] = 32'hD000_0000 + i;
   end
   always @(posedge clk) begin
      if (prog_we) prog_mem[prog_addr] <= prog_wdata;
      if (data_we) data_mem[data_addr] <= data_wdata;
   end
   assign prog_rdata = prog_mem[prog_addr];
   assign data_rdata = data_mem[data_addr];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_exp(logic h, logic [7:0] st, logic [7:0] cm);
      return {h, 15'd0, st, cm};
   endfunction

   function automatic logic [7:0] next_cmd(logic [7:0] cm, logic hwe, logic [7:0] hwd,
                                           logic aut, logic swe, logic [7:0] swd);
      logic [7:0] clr = swe ? ~swd : 8'h00;
      logic [7:0] set = (hwe ? hwd : 8'h00) | {7'd0, aut};
      return (cm & ~clr) | set;
   endfunction

   function automatic logic exp_run(logic cr, logic [7:0] st);
      return cr | ~st[0];
   endfunction

   task automatic idle();
      h_csr_we = 0; h_fn_we = 0; s_we = 0; h_mem_rd = 0; h_mem_wr = 0;
   endtask

   // apply current inputs at a negedge, advance one cycle, update model, check register
   task automatic cycle(input string tag);
      logic aut = h_fn_we & h_fn_run & (|h_fn_op);
      logic [7:0] nc = next_cmd(e_cmd, h_csr_we, h_csr_wdata[7:0], aut, s_we, s_wdata[7:0]);
      logic nh = (h_csr_we && !exp_run(core_run, e_stat)) ? h_csr_wdata[31] : e_hold;
      logic [7:0] ns = s_we ? s_wdata[15:8] : e_stat;
      #1;
      chk({tag, " R4 run_vis"}, {31'd0, run_vis}, {31'd0, exp_run(core_run, e_stat)});
      @(negedge clk);
      e_cmd = nc; e_hold = nh; e_stat = ns;
      chk({tag, " register"}, h_csr_rdata, pack_exp(e_hold, e_stat, e_cmd));
      idle();
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      e_hold = 1'b1; e_stat = 8'h01; e_cmd = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 reset word", h_csr_rdata, 32'h8000_0100);
      chk("R1 seq_rst", {31'd0, seq_rst}, 32'd1);
      chk("R4 irq after reset", {31'd0, seq_irq}, 32'd0);

      // R9 program open while held
      h_mem_sel = 0; h_mem_wr = 1; h_mem_addr = 4'd3; h_mem_wdata = 32'h1234_5678;
      #1 chk("R9 prog write strobe", {31'd0, prog_we}, 32'd1);
      @(negedge clk); idle();
      h_mem_sel = 0; h_mem_rd = 1; h_mem_addr = 4'd3;
      #1 chk("R9 prog read held", h_mem_rdata, 32'h1234_5678);
      @(negedge clk); idle();
      // R10 data blocked while held
      h_mem_sel = 1; h_mem_wr = 1; h_mem_addr = 4'd5; h_mem_wdata = 32'hBAD0_BAD0;
      #1 chk("R10 blocked write strobe", {31'd0, data_we}, 32'd0);
      @(negedge clk); idle();
      h_mem_sel = 1; h_mem_rd = 1; h_mem_addr = 4'd5;
      #1 chk("R10 blocked read zero", h_mem_rdata, 32'd0);
      chk("R10 blocked read strobe", {31'd0, data_re}, 32'd0);
      @(negedge clk); idle();

      // R2 release sequencer
      h_csr_we = 1; h_csr_wdata = 32'h0000_0000;
      cycle("R2 release");
      chk("R2 seq_rst low", {31'd0, seq_rst}, 32'd0);
      // R9 swap, R10 dropped write not present
      h_mem_sel = 1; h_mem_rd = 1; h_mem_addr = 4'd5;
      #1 chk("R10 dropped write absent", h_mem_rdata, 32'hD000_0005);
      @(negedge clk); idle();
      h_mem_sel = 0; h_mem_rd = 1; h_mem_addr = 4'd3;
      #1 chk("R9 prog closed after release", h_mem_rdata, 32'd0);
      chk("R9 prog read strobe closed", {31'd0, prog_re}, 32'd0);
      @(negedge clk); idle();

      // R2 locked while core busy
      core_run = 1; h_csr_we = 1; h_csr_wdata = 32'h8000_0000;
      cycle("R2 locked write");
      chk("R2 hold ignored while run", {31'd0, seq_rst}, 32'd0);
      core_run = 0;

      // R3 host cannot write status; R4 irq from status
      h_csr_we = 1; h_csr_wdata = 32'h0000_FE00;
      cycle("R3 host status write");
      s_we = 1; s_wdata = 16'h00FF;
      cycle("R3 seq status write");
      chk("R4 irq high", {31'd0, seq_irq}, 32'd1);
      // R2 lock via sequencer busy
      h_csr_we = 1; h_csr_wdata = 32'h8000_0000;
      cycle("R2 locked by irq");
      s_we = 1; s_wdata = 16'h01FF;
      cycle("R4 status restored");

      // R8 auto start
      h_fn_we = 1; h_fn_run = 1; h_fn_op = 3'd0;
      cycle("R8 op zero");
      chk("R8 no post on op zero", {31'd0, s_cmd[0]}, 32'd0);
      h_fn_we = 1; h_fn_run = 0; h_fn_op = 3'd4;
      cycle("R8 run low");
      h_fn_we = 1; h_fn_run = 1; h_fn_op = 3'd5;
      cycle("R8 op nonzero");
      chk("R8 bit0 posted", {31'd0, s_cmd[0]}, 32'd1);

      // R5 / R6 / R7 directed
      h_csr_we = 1; h_csr_wdata = 32'h0000_00A0;
      cycle("R5 host set");
      h_csr_we = 1; h_csr_wdata = 32'h0000_0000;
      cycle("R5 host zero no effect");
      s_we = 1; s_wdata = 16'h01DF;
      cycle("R6 seq clear bit5");
      s_we = 1; s_wdata = 16'h01FF;
      cycle("R6 seq ones no effect");
      h_csr_we = 1; h_csr_wdata = 32'h0000_0004; s_we = 1; s_wdata = 16'h0100;
      cycle("R7 conflict");
      chk("R7 host wins bit2", {31'd0, s_cmd[2]}, 32'd1);

      // random mix
      for (int n = 0; n < 400; n++) begin
         logic [31:0] r = $urandom;
         h_csr_we    = r[0];
         h_csr_wdata = {r[1] & r[2], 15'd0, 8'($urandom), 8'($urandom) & 8'($urandom)};
         s_we        = r[3];
         s_wdata     = {7'($urandom), r[4] | r[5], 8'($urandom) | 8'($urandom)};
         h_fn_we     = r[6];
         h_fn_run    = r[7];
         h_fn_op     = r[10:8];
         core_run    = r[11] & r[12];
         cycle("R5 R6 R7 R8 random");
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule